// File: doc/BRIEF.md
# Random tag generator with exclusion

This unit assigns a 4-bit allocation tag to a 64-bit pointer. The tag sits in bits [59:56] of the pointer; every other bit passes through unchanged. The unit holds a state register with a 16-bit pseudo-random seed and the most recently generated tag.

It has two operating modes. In random mode, the seed is stepped four times through a 16-bit Fibonacci LFSR, and the four feedback bits form a step count. The walk starts from the stored tag, skips every tag value flagged in the combined exclusion mask, and the tag it lands on is written back as the next start point. In add mode, the walk starts from the pointer's own tag and steps by an explicit 4-bit amount, using only the configuration mask. The address is also moved by a signed byte offset, and the state register is not touched.

The walk examines one candidate tag per clock, so a request takes a variable number of cycles. A request is accepted while the unit is idle, `busy_o` covers the walk, and a one-cycle `done_o` marks the result. A synchronous load port presets the seed and start tag.

Top module: `tag_gen`

## Requirements
- R1: In random mode (`mode_i`=0) the exclusion mask is `excl_i | cfg_excl_i`. In add mode (`mode_i`=1) the mask is `cfg_excl_i` alone, and `excl_i` has no effect. Bit k of a mask set means tag value k may not be produced.
- R2: If the effective mask is all ones, the result tag is 0, whatever the start tag or step count.
- R3: With a step count of zero, the result is the start tag if that tag is allowed. Otherwise the tag is incremented modulo 16 until it reaches an allowed value.
- R4: With a non-zero step count n, the tag advances modulo 16 to the next allowed value, n times in succession.
- R5: One LFSR step computes feedback = seed[5]^seed[3]^seed[2]^seed[0], shifts the seed right by one, and places the feedback bit in bit 15.
- R6: A random-mode request makes exactly four LFSR steps. The feedback bit of step i (i = 0..3) is bit i of the step count.
- R7: After a random-mode request, `state_o[3:0]` holds the new tag and `state_o[23:8]` holds the seed after four steps; `state_o[7:4]` always reads 0. The stored tag is the start tag of the next random request. The stored tag does not change while `busy_o` is high.
- R8: In add mode, the start tag is `ptr_i[59:56]` and the step count is `tag_ofs_i`. The output address is `ptr_i` plus the sign-extended `addr_ofs_i` (modulo 2^64), with bits [59:56] then replaced by the result. `state_o` is unchanged.
- R9: In random mode, `ptr_o` equals the accepted `ptr_i` with only bits [59:56] replaced by the result tag.
- R10: A request is accepted on a clock edge where `start_i`=1, `busy_o`=0 and `load_i`=0. `busy_o` is high from the next cycle until the walk ends. `done_o` is then high for exactly one cycle, with `busy_o` low. `ptr_o` changes only when `done_o` rises. A `start_i` pulse while busy has no effect.
- R11: While idle, `load_i`=1 writes `load_state_i[23:8]` to the seed and `load_state_i[3:0]` to the tag; `state_o` shows them on the next cycle. A load while busy has no effect.
- R12: The walk takes one clock per candidate examined. The worst case is step count 15 with a single allowed value: 240 walk cycles, with `done_o` at the 241st edge after acceptance. `busy_o` never lasts more than 240 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| mode_i | input | 1 | 0 = random tag, 1 = add tag offset |
| ptr_i | input | 64 | Input pointer |
| excl_i | input | 16 | Per-request exclusion mask (random mode) |
| cfg_excl_i | input | 16 | Configuration exclusion mask |
| tag_ofs_i | input | 4 | Tag step count (add mode) |
| addr_ofs_i | input | 16 | Signed byte offset (add mode) |
| load_i | input | 1 | Synchronous state load |
| load_state_i | input | 24 | State value to load |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle result strobe |
| ptr_o | output | 64 | Result pointer |
| state_o | output | 24 | Seed in [23:8], stored tag in [3:0] |

## Verification
The assertions check the following on every cycle:
- the request handshake, the one-cycle `done_o` strobe and the holding of `ptr_o` between results;
- that the load port writes state only while idle;
- that only the tag field of a random-mode pointer changes;
- the zero tag under a full mask, and the stored tag's steadiness during a walk;
- the bound on busy time.

Whether the right tag is chosen can only be shown by the bench scenarios. These compare the LFSR step count, the skip walk with its wraparound, the zero-step case and the add-mode address arithmetic against an independent model, over directed corner cases and random masks.

// File: rtl/tag_gen_pkg.sv
package tag_gen_pkg;
  localparam int unsigned PTR_W    = 64;
  localparam int unsigned TAG_W    = 4;
  localparam int unsigned TAG_LSB  = 56;
  localparam int unsigned SEED_W   = 16;
  localparam int unsigned SEED_LSB = 8;
  localparam int unsigned STEPS    = 4;
  localparam int unsigned AOFS_W   = 16;
  localparam int unsigned NTAG     = 1 << TAG_W;
  localparam int unsigned STATE_W  = SEED_LSB + SEED_W;
  // feedback taps of the seed register
  localparam int unsigned TAP_A = 5;
  localparam int unsigned TAP_B = 3;
  localparam int unsigned TAP_C = 2;
  localparam int unsigned TAP_D = 0;

  typedef enum logic {
    MODE_RAND = 1'b0,
    MODE_ADD  = 1'b1
  } gen_mode_e;
endpackage

// File: rtl/tag_lfsr.sv
module tag_lfsr
  import tag_gen_pkg::*;
#(
  parameter int unsigned SW = SEED_W,
  parameter int unsigned NS = STEPS
) (
  input  logic [SW-1:0] seed_i,
  output logic [SW-1:0] seed_o,
  output logic [NS-1:0] bits_o
);
  logic [NS:0][SW-1:0] chain;

  assign chain[0] = seed_i;

  for (genvar i = 0; i < NS; i++) begin : g_step
    logic fb;
    assign fb = chain[i][TAP_A] ^ chain[i][TAP_B] ^ chain[i][TAP_C] ^ chain[i][TAP_D];
    assign chain[i+1] = {fb, chain[i][SW-1:1]};
    assign bits_o[i] = fb;
  end

  assign seed_o = chain[NS];
endmodule

// File: rtl/tag_walker.sv
module tag_walker
  import tag_gen_pkg::*;
#(
  parameter int unsigned TW = TAG_W,
  localparam int unsigned NT = 1 << TW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [TW-1:0] tag_i,
  input  logic [TW-1:0] ofs_i,
  input  logic [NT-1:0] mask_i,
  output logic          busy_o,
  output logic          fin_o,
  output logic [TW-1:0] res_o
);
  logic          busy_q, chk_cur_q;
  logic [TW-1:0] cur_q, rem_q, nxt;
  logic [NT-1:0] mask_q;

  assign nxt = cur_q + 1'b1;

  always_comb begin
    fin_o = 1'b0;
    res_o = cur_q;
    if (busy_q) begin
      if (&mask_q) begin
        fin_o = 1'b1;
        res_o = '0;
      end else if (chk_cur_q) begin
        fin_o = ~mask_q[cur_q];
      end else if (!mask_q[nxt] && rem_q == TW'(1)) begin
        fin_o = 1'b1;
        res_o = nxt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      chk_cur_q <= 1'b0;
      cur_q     <= '0;
      rem_q     <= '0;
      mask_q    <= '0;
    end else if (go_i) begin
      busy_q    <= 1'b1;
      cur_q     <= tag_i;
      rem_q     <= ofs_i;
      chk_cur_q <= (ofs_i == '0);
      mask_q    <= mask_i;
    end else if (busy_q) begin
      if (fin_o) begin
        busy_q <= 1'b0;
      end else begin
        cur_q <= nxt;
        // zero-step walk checks each candidate itself; stepped walk counts allowed hits
        if (!chk_cur_q && !mask_q[nxt]) rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/tag_gen.sv
module tag_gen
  import tag_gen_pkg::*;
#(
  parameter int unsigned PW  = PTR_W,
  parameter int unsigned TW  = TAG_W,
  parameter int unsigned TL  = TAG_LSB,
  parameter int unsigned SW  = SEED_W,
  parameter int unsigned SL  = SEED_LSB,
  parameter int unsigned AW  = AOFS_W,
  localparam int unsigned NT = 1 << TW,
  localparam int unsigned STW = SL + SW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           mode_i,
  input  logic [PW-1:0]  ptr_i,
  input  logic [NT-1:0]  excl_i,
  input  logic [NT-1:0]  cfg_excl_i,
  input  logic [TW-1:0]  tag_ofs_i,
  input  logic [AW-1:0]  addr_ofs_i,
  input  logic           load_i,
  input  logic [STW-1:0] load_state_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [PW-1:0]  ptr_o,
  output logic [STW-1:0] state_o
);
  logic [SW-1:0] seed_q, seed_nxt;
  logic [TW-1:0] tag_q, lfsr_bits;
  logic [PW-1:0] base_q, ptr_q;
  logic          add_q, done_q;

  logic          accept, is_add, walk_busy, walk_fin;
  logic [TW-1:0] walk_tag, walk_ofs, walk_res;
  logic [NT-1:0] walk_mask;
  logic [PW-1:0] base_d;

  tag_lfsr #(.SW(SW), .NS(TW)) u_lfsr (
    .seed_i (seed_q),
    .seed_o (seed_nxt),
    .bits_o (lfsr_bits)
  );

  assign is_add = (gen_mode_e'(mode_i) == MODE_ADD);
  assign accept = start_i && !walk_busy && !load_i;

  always_comb begin
    if (is_add) begin
      walk_tag  = ptr_i[TL +: TW];
      walk_ofs  = tag_ofs_i;
      walk_mask = cfg_excl_i;
      base_d    = ptr_i + {{(PW-AW){addr_ofs_i[AW-1]}}, addr_ofs_i};
    end else begin
      walk_tag  = tag_q;
      walk_ofs  = lfsr_bits;
      walk_mask = excl_i | cfg_excl_i;
      base_d    = ptr_i;
    end
  end

  tag_walker #(.TW(TW)) u_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (accept),
    .tag_i  (walk_tag),
    .ofs_i  (walk_ofs),
    .mask_i (walk_mask),
    .busy_o (walk_busy),
    .fin_o  (walk_fin),
    .res_o  (walk_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q <= '0;
      tag_q  <= '0;
      base_q <= '0;
      add_q  <= 1'b0;
      ptr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= walk_fin;
      if (load_i && !walk_busy) begin
        seed_q <= load_state_i[SL +: SW];
        tag_q  <= load_state_i[TW-1:0];
      end else if (accept) begin
        base_q <= base_d;
        add_q  <= is_add;
        if (!is_add) seed_q <= seed_nxt;
      end
      if (walk_fin) begin
        ptr_q <= base_q;
        ptr_q[TL +: TW] <= walk_res;
        if (!add_q) tag_q <= walk_res;
      end
    end
  end

  assign busy_o  = walk_busy;
  assign done_o  = done_q;
  assign ptr_o   = ptr_q;
  assign state_o = {seed_q, {(SL-TW){1'b0}}, tag_q};
endmodule

// File: rtl/tag_gen_chk.sv
module tag_gen_chk
  import tag_gen_pkg::*;
#(
  parameter int unsigned PW  = PTR_W,
  parameter int unsigned TW  = TAG_W,
  parameter int unsigned TL  = TAG_LSB,
  parameter int unsigned SW  = SEED_W,
  parameter int unsigned SL  = SEED_LSB,
  localparam int unsigned NT = 1 << TW,
  localparam int unsigned STW = SL + SW,
  localparam int unsigned LAT_MAX = NT * (NT - 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           mode_i,
  input logic [PW-1:0]  ptr_i,
  input logic [NT-1:0]  excl_i,
  input logic [NT-1:0]  cfg_excl_i,
  input logic           load_i,
  input logic [STW-1:0] load_state_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [PW-1:0]  ptr_o,
  input logic [STW-1:0] state_o
);
  localparam logic [PW-1:0] FIELD = PW'({TW{1'b1}}) << TL;

  logic [PW-1:0]  cap_ptr;
  logic [STW-1:0] cap_state;
  logic           cap_add, cap_full;
  logic [15:0]    lat_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_ptr   <= '0;
      cap_state <= '0;
      cap_add   <= 1'b0;
      cap_full  <= 1'b0;
      lat_cnt   <= '0;
    end else begin
      lat_cnt <= busy_o ? lat_cnt + 16'd1 : 16'd0;
      if (start_i && !busy_o && !load_i) begin
        cap_ptr   <= ptr_i;
        cap_state <= state_o;
        cap_add   <= mode_i;
        cap_full  <= mode_i ? (&cfg_excl_i) : (&(excl_i | cfg_excl_i));
      end
    end
  end

  a_r10_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !load_i) |=> busy_o);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r10_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(ptr_o));
  a_r11_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o) |=> (state_o[SL +: SW] == $past(load_state_i[SL +: SW]) &&
                             state_o[TW-1:0] == $past(load_state_i[TW-1:0])));
  a_r7_tag_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $stable(state_o[TW-1:0]));
  a_r7_tag_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cap_add) |-> state_o[TW-1:0] == ptr_o[TL +: TW]);
  a_r8_state_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_add) |-> state_o == cap_state);
  a_r9_field_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cap_add) |-> (ptr_o & ~FIELD) == (cap_ptr & ~FIELD));
  a_r2_full_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_full) |-> ptr_o[TL +: TW] == '0);
  a_r12_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (32'(lat_cnt) < LAT_MAX));
endmodule

bind tag_gen tag_gen_chk #(.PW(PW), .TW(TW), .TL(TL), .SW(SW), .SL(SL)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .mode_i       (mode_i),
  .ptr_i        (ptr_i),
  .excl_i       (excl_i),
  .cfg_excl_i   (cfg_excl_i),
  .load_i       (load_i),
  .load_state_i (load_state_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .ptr_o        (ptr_o),
  .state_o      (state_o)
);

// File: tb/tag_gen_tb.sv
module tag_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mode = 1'b0, load = 1'b0;
  logic [63:0] ptr = '0;
  logic [15:0] excl = '0, cfg = '0;
  logic [3:0]  tofs = '0;
  logic [15:0] aofs = '0;
  logic [23:0] ld_state = '0;
  logic        busy, done;
  logic [63:0] ptr_out;
  logic [23:0] state;

  int errors = 0, checks = 0;
  logic [15:0] m_seed = '0;
  logic [3:0]  m_tag = '0;

  always #5 clk = ~clk;

  tag_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .ptr_i(ptr),
    .excl_i(excl), .cfg_excl_i(cfg), .tag_ofs_i(tofs), .addr_ofs_i(aofs),
    .load_i(load), .load_state_i(ld_state), .busy_o(busy), .done_o(done),
    .ptr_o(ptr_out), .state_o(state)
  );

  function automatic logic [19:0] lfsr4(input logic [15:0] s);
    logic [3:0] o;
    logic fb;
    for (int i = 0; i < 4; i++) begin
      fb = s[5] ^ s[3] ^ s[2] ^ s[0];
      s = {fb, s[15:1]};
      o[i] = fb;
    end
    return {o, s};
  endfunction

  function automatic logic [3:0] walk(input logic [3:0] t, input logic [3:0] n, input logic [15:0] m);
    if (m == 16'hffff) return 4'h0;
    if (n == 4'h0) begin
      while (m[t]) t = t + 4'd1;
    end else begin
      for (int k = 0; k < int'(n); k++) begin
        t = t + 4'd1;
        while (m[t]) t = t + 4'd1;
      end
    end
    return t;
  endfunction

  function automatic logic [63:0] put_tag(input logic [63:0] p, input logic [3:0] t);
    p[59:56] = t;
    return p;
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_load(input logic [23:0] v);
    @(negedge clk);
    load = 1'b1; ld_state = v;
    @(negedge clk);
    load = 1'b0;
    m_seed = v[23:8]; m_tag = v[3:0];
  endtask

  task automatic run_req(input logic md, input logic [63:0] p, input logic [15:0] e,
                         input logic [15:0] c, input logic [3:0] to, input logic [15:0] ao,
                         input string rq, output int lat);
    logic [19:0] l;
    logic [3:0]  t;
    logic [63:0] exp_ptr;
    if (md == 1'b0) begin
      l = lfsr4(m_seed);
      t = walk(m_tag, l[19:16], e | c);
      exp_ptr = put_tag(p, t);
      m_tag = t; m_seed = l[15:0];
    end else begin
      t = walk(p[59:56], to, c);
      exp_ptr = put_tag(p + {{48{ao[15]}}, ao}, t);
    end
    @(negedge clk);
    start = 1'b1; mode = md; ptr = p; excl = e; cfg = c; tofs = to; aofs = ao;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    chk({rq, " ptr"}, ptr_out, exp_ptr);
    chk({rq, " state"}, 64'(state), 64'({m_seed, 4'h0, m_tag}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int lat;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R10 reset busy", 64'(busy), 64'd0);
    chk("R10 reset done", 64'(done), 64'd0);
    chk("R7 reset state", 64'(state), 64'd0);
    chk("R10 reset ptr", ptr_out, 64'd0);

    // R11: load, bits 7:4 read zero
    do_load(24'hACE1_F3);
    chk("R11 load", 64'(state), 64'h00ACE103);

    // R5 R6 R9: random request from known seed, no exclusion
    run_req(1'b0, 64'h1234_5678_9ABC_DEF0, 16'h0, 16'h0, 4'h0, 16'h0, "R5 R6 R9 random", lat);

    // R3 R1: zero seed gives zero step; start 5 excluded by cfg, 6 by request
    do_load(24'h0000_05);
    run_req(1'b0, 64'h0F00_0000_0000_0040, 16'h0040, 16'h0020, 4'h0, 16'h0, "R3 R1 zero step", lat);
    chk("R3 tag 7", 64'(ptr_out[59:56]), 64'd7);

    // R2: full mask gives 0, seed still advances
    do_load(24'h1D2B_09);
    run_req(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFF00, 16'h00FF, 4'h0, 16'h0, "R2 full mask", lat);
    chk("R2 tag 0", 64'(ptr_out[59:56]), 64'd0);

    // R1: add mode ignores excl_i (start 4 excluded only by request mask)
    run_req(1'b1, 64'h0400_0000_0000_0100, 16'h0010, 16'h0000, 4'h0, 16'h0, "R1 add ignores request mask", lat);
    chk("R1 tag 4", 64'(ptr_out[59:56]), 64'd4);

    // R4 R8: wrap past 15 with skips, negative address offset
    run_req(1'b1, 64'h0E00_0000_0000_1000, 16'h0, 16'h8002, 4'h3, 16'hFFF0, "R4 R8 add wrap", lat);
    chk("R4 tag 3", 64'(ptr_out[59:56]), 64'd3);
    chk("R8 address", ptr_out & ~64'h0F00_0000_0000_0000, 64'h0000_0000_0000_0FF0);

    // R12: worst case, single allowed value
    run_req(1'b1, 64'h0000_0000_0000_0000, 16'h0, 16'hFFFE, 4'hF, 16'h0, "R12 worst walk", lat);
    chk("R12 latency", 64'(lat), 64'd241);
    @(negedge clk);
    chk("R10 done one cycle", 64'(done), 64'd0);

    // R10 R11: start and load while busy are ignored
    begin
      logic [63:0] exp_p;
      exp_p = put_tag(64'h0300_0000_0000_2000, walk(4'h3, 4'hF, 16'h0));
      @(negedge clk);
      start = 1'b1; mode = 1'b1; ptr = 64'h0300_0000_0000_2000; cfg = 16'h0; excl = 16'h0;
      tofs = 4'hF; aofs = 16'h0;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk("R10 busy", 64'(busy), 64'd1);
      start = 1'b1; mode = 1'b0; ptr = 64'hDEAD_BEEF_0000_0000; load = 1'b1; ld_state = 24'h5555_0A;
      @(negedge clk);
      start = 1'b0; load = 1'b0;
      while (!done) @(negedge clk);
      chk("R10 start while busy ignored", ptr_out, exp_p);
      chk("R11 load while busy ignored", 64'(state), 64'({m_seed, 4'h0, m_tag}));
      @(negedge clk);
      chk("R10 no second request", 64'(busy), 64'd0);
    end

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [15:0] e, c;
      logic md;
      md = 1'($urandom % 2);
      e = 16'($urandom & $urandom & $urandom);
      c = 16'($urandom & $urandom & $urandom);
      if ($urandom % 25 == 0) c = 16'hFFFF;
      if ($urandom % 40 == 0) do_load(24'($urandom));
      run_req(md, {$urandom, $urandom}, e, c, 4'($urandom), 16'($urandom),
              md ? "R8 R4 random add" : "R6 R7 R9 random gen", lat);
      if (lat > 241) chk("R12 random latency", 64'(lat), 64'd241);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule